// File: doc/BRIEF.md
# Pointer Register Address Generator

This block turns a pointer selection into a data-RAM address for a small 16-bit signal processor. It keeps eight 8-bit pointer registers split evenly across two data-RAM banks of 256 words. The upper index bit picks the bank. The last pointer of each bank is hard-wired to the bank start and cannot be written. When one of these fixed pointers is selected, its 2-bit modifier field acts as a direct word address from 0 to 3. For the other pointers, the modifier selects one of four actions after the access: keep the pointer, increment it, decrement it, or increment it without wrap. A 3-bit loop-size field from the status register can confine increments and decrements to a window of 2^N words.

A second-level indirect access takes three cycles and runs through a small sequencer with three states:

- **IDLE** accepts requests.
- **FETCH** presents the RAM word as a program-memory address.
- **WBACK** writes that word back plus one.

The transitions are:

- IDLE→FETCH on a valid double-indirect request.
- FETCH→WBACK unconditionally.
- WBACK→IDLE unconditionally.

A double-indirect request that names a writable pointer together with a nonzero modifier is rejected. The block flags it and changes nothing. An explicit pointer write can land in the same cycle as a post-modify. If both target the same register, the write wins.

Top module: `ptr_agu`

## Requirements
- R1: After reset all pointers read 0, busy, ram_en, ram_we, pm_valid and invalid are low.
- R2: With pw_en high, pw_data is stored in writable pointer pw_idx and is visible on peek_val from the next cycle.
- R3: Pointers 3 and 7 ignore writes and always read 0.
- R4: An accepted access drives ram_en in the same cycle. ram_bank equals acc_idx bit 2, and ram_addr equals the selected pointer value.
- R5: When acc_idx[1:0] is 3, ram_addr is the modifier value (0 to 3) in the selected bank, and no pointer changes.
- R6: The modifier codes act after a single-level access as follows, all wrapping modulo 256 when loop_size is 0:
  - 00 leaves the pointer unchanged.
  - 01 adds 1 and ignores loop_size.
  - 10 subtracts 1.
  - 11 adds 1.
- R7: With loop_size N nonzero, codes 10 and 11 change only the low N bits of the pointer (wrap modulo 2^N), and the upper bits are kept.
- R8: A valid double-indirect access behaves as follows:
  - In the accept cycle it reads the RAM word at the pointer address.
  - In the next cycle pm_valid is high and pm_addr equals ram_rdata.
  - In the cycle after that, ram_we writes ram_rdata+1 (modulo 2^16) to the same bank and address.
  - busy is high in both later cycles, and the pointer itself is unchanged.
- R9: A double-indirect request with a nonzero modifier on pointers 0–2 or 4–6 raises invalid in its cycle. It gives no RAM access, no pointer change and no busy.
- R10: A pointer write and a post-modify in the same cycle to the same pointer leave the written value. When they target different pointers, both take effect.
- R11: Requests arriving while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request |
| acc_idx | input | 3 | Pointer index; bit 2 is the bank |
| acc_mod | input | 2 | Modifier code |
| acc_dbl | input | 1 | Second-level indirect request |
| loop_size | input | 3 | Modulo window exponent, 0 = off |
| pw_en | input | 1 | Pointer write enable |
| pw_idx | input | 3 | Pointer write index |
| pw_data | input | 8 | Pointer write value |
| peek_idx | input | 3 | Pointer read index |
| peek_val | output | 8 | Pointer read value |
| ram_en | output | 1 | Data-RAM access strobe |
| ram_bank | output | 1 | Data-RAM bank select |
| ram_addr | output | 8 | Data-RAM word address |
| ram_we | output | 1 | Data-RAM write strobe |
| ram_wdata | output | 16 | Data-RAM write data |
| ram_rdata | input | 16 | Data-RAM read data, one cycle after ram_en |
| pm_valid | output | 1 | Program-memory address valid |
| pm_addr | output | 16 | Program-memory address |
| busy | output | 1 | Double-indirect sequence in progress |
| invalid | output | 1 | Rejected double-indirect request |

## Verification
The address, bank, strobe and invalid outputs respond combinationally in the cycle of the request, so the bench samples them a moment after driving inputs at the falling edge. Pointer updates and writes land on the next rising edge and are read through peek_val at the following falling edge. For a double-indirect access, the bench places the RAM word on ram_rdata one cycle after the accept and expects pm_addr in that same cycle. It then expects the write-back one cycle later and busy low one cycle after that.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WBACK = 2'd2
    } agu_state_t;

    typedef enum logic [1:0] {
        MOD_KEEP    = 2'b00,
        MOD_INC_RAW = 2'b01,
        MOD_DEC     = 2'b10,
        MOD_INC     = 2'b11
    } agu_mod_t;

endpackage

// File: rtl/ptr_step.sv
module ptr_step
    import ptr_agu_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int LOOP_W = 3
) (
    input  logic [PTR_W-1:0]  cur,
    input  logic [1:0]        mod_code,
    input  logic [LOOP_W-1:0] loop_size,
    output logic [PTR_W-1:0]  nxt
);
    logic [PTR_W-1:0] win_mask;
    logic [PTR_W-1:0] plus_one;
    logic [PTR_W-1:0] minus_one;

    // window mask: all ones when the loop field is off or covers the width
    always_comb begin
        if (loop_size == '0 || int'(loop_size) >= PTR_W)
            win_mask = '1;
        else
            win_mask = (PTR_W'(1) << loop_size) - PTR_W'(1);
    end

    assign plus_one  = cur + PTR_W'(1);
    assign minus_one = cur - PTR_W'(1);

    always_comb begin
        unique case (agu_mod_t'(mod_code))
            MOD_KEEP:    nxt = cur;
            MOD_INC_RAW: nxt = plus_one;
            MOD_DEC:     nxt = (cur & ~win_mask) | (minus_one & win_mask);
            MOD_INC:     nxt = (cur & ~win_mask) | (plus_one & win_mask);
            default:     nxt = cur;
        endcase
    end
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile #(
    parameter int NUM_PTR = 8,
    parameter int PTR_W   = 8,
    localparam int IDX_W    = $clog2(NUM_PTR),
    localparam int PER_BANK = NUM_PTR / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [PTR_W-1:0] upd_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PTR_W-1:0] wr_val,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [PTR_W-1:0] rd_a_val,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [PTR_W-1:0] rd_b_val
);
    logic [PTR_W-1:0] ptr_q [NUM_PTR];

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        if ((g % PER_BANK) == PER_BANK - 1) begin : g_fixed
            // bank-start pointer: constant zero
            assign ptr_q[g] = '0;
        end else begin : g_rw
            logic [PTR_W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_idx == IDX_W'(g))
                    q <= wr_val;            // explicit write wins
                else if (upd_en && upd_idx == IDX_W'(g))
                    q <= upd_val;
            end
            assign ptr_q[g] = q;
        end
    end

    assign rd_a_val = ptr_q[rd_a_idx];
    assign rd_b_val = ptr_q[rd_b_idx];
endmodule

// File: rtl/ptr_dbl_seq.sv
module ptr_dbl_seq
    import ptr_agu_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_bank,
    input  logic [PTR_W-1:0]  start_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              busy,
    output logic              pm_valid,
    output logic [DATA_W-1:0] pm_addr,
    output logic              wb_we,
    output logic [DATA_W-1:0] wb_data,
    output logic              hold_bank,
    output logic [PTR_W-1:0]  hold_addr
);
    agu_state_t        state, state_nxt;
    logic [DATA_W-1:0] word_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // datapath holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_bank <= 1'b0;
            hold_addr <= '0;
            word_q    <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                hold_bank <= start_bank;
                hold_addr <= start_addr;
            end
            if (state == ST_FETCH)
                word_q <= ram_rdata;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        busy      = 1'b0;
        pm_valid  = 1'b0;
        pm_addr   = '0;
        wb_we     = 1'b0;
        wb_data   = '0;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nxt = ST_FETCH;
            end
            ST_FETCH: begin
                busy      = 1'b1;
                pm_valid  = 1'b1;
                pm_addr   = ram_rdata;
                state_nxt = ST_WBACK;
            end
            ST_WBACK: begin
                busy      = 1'b1;
                wb_we     = 1'b1;
                wb_data   = word_q + DATA_W'(1);
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import ptr_agu_pkg::*;
#(
    parameter int NUM_PTR = 8,
    parameter int PTR_W   = 8,
    parameter int DATA_W  = 16,
    parameter int LOOP_W  = 3,
    localparam int IDX_W  = $clog2(NUM_PTR),
    localparam int LOW_W  = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [1:0]        acc_mod,
    input  logic              acc_dbl,
    input  logic [LOOP_W-1:0] loop_size,
    input  logic              pw_en,
    input  logic [IDX_W-1:0]  pw_idx,
    input  logic [PTR_W-1:0]  pw_data,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [PTR_W-1:0]  peek_val,
    output logic              ram_en,
    output logic              ram_bank,
    output logic [PTR_W-1:0]  ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              pm_valid,
    output logic [DATA_W-1:0] pm_addr,
    output logic              busy,
    output logic              invalid
);
    logic             sel_bank, sel_fixed, accept, bad_dbl;
    logic             go_single, go_dbl;
    logic [PTR_W-1:0] sel_val, stepped, addr_now;
    logic             wb_we, hold_bank;
    logic [PTR_W-1:0] hold_addr;
    logic [DATA_W-1:0] wb_data;

    assign sel_bank  = acc_idx[IDX_W-1];
    assign sel_fixed = (acc_idx[LOW_W-1:0] == '1);
    assign accept    = acc_valid && !busy;
    assign bad_dbl   = acc_dbl && !sel_fixed && (acc_mod != 2'b00);
    assign go_single = accept && !acc_dbl;
    assign go_dbl    = accept && acc_dbl && !bad_dbl;
    assign invalid   = accept && bad_dbl;
    assign addr_now  = sel_fixed ? {{(PTR_W-2){1'b0}}, acc_mod} : sel_val;

    ptr_regfile #(.NUM_PTR(NUM_PTR), .PTR_W(PTR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (go_single && !sel_fixed),
        .upd_idx  (acc_idx),
        .upd_val  (stepped),
        .wr_en    (pw_en),
        .wr_idx   (pw_idx),
        .wr_val   (pw_data),
        .rd_a_idx (acc_idx),
        .rd_a_val (sel_val),
        .rd_b_idx (peek_idx),
        .rd_b_val (peek_val)
    );

    ptr_step #(.PTR_W(PTR_W), .LOOP_W(LOOP_W)) u_step (
        .cur       (sel_val),
        .mod_code  (acc_mod),
        .loop_size (loop_size),
        .nxt       (stepped)
    );

    ptr_dbl_seq #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (go_dbl),
        .start_bank (sel_bank),
        .start_addr (addr_now),
        .ram_rdata  (ram_rdata),
        .busy       (busy),
        .pm_valid   (pm_valid),
        .pm_addr    (pm_addr),
        .wb_we      (wb_we),
        .wb_data    (wb_data),
        .hold_bank  (hold_bank),
        .hold_addr  (hold_addr)
    );

    assign ram_en    = go_single || go_dbl || wb_we;
    assign ram_we    = wb_we;
    assign ram_wdata = wb_data;
    assign ram_bank  = busy ? hold_bank : sel_bank;
    assign ram_addr  = busy ? hold_addr : addr_now;
endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
    parameter int NUM_PTR = 8,
    parameter int PTR_W   = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_PTR)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [IDX_W-1:0]  acc_idx,
    input logic [1:0]        acc_mod,
    input logic              acc_dbl,
    input logic [IDX_W-1:0]  peek_idx,
    input logic [PTR_W-1:0]  peek_val,
    input logic              ram_en,
    input logic              ram_bank,
    input logic [PTR_W-1:0]  ram_addr,
    input logic              ram_we,
    input logic [DATA_W-1:0] ram_wdata,
    input logic [DATA_W-1:0] ram_rdata,
    input logic              pm_valid,
    input logic              busy,
    input logic              invalid
);
    logic idx_fixed, peek_fixed;
    assign idx_fixed  = (acc_idx[IDX_W-2:0] == '1);
    assign peek_fixed = (peek_idx[IDX_W-2:0] == '1);

    assert_fixed_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        peek_fixed |-> peek_val == '0);

    assert_fixed_direct_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !busy && idx_fixed) |-> (ram_addr == PTR_W'(acc_mod) && ram_en));

    assert_fetch_follows_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_dbl && !busy && !invalid)
        |=> (pm_valid && busy && ram_addr == $past(ram_addr) && ram_bank == $past(ram_bank)));

    assert_writeback_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pm_valid |=> (ram_we && ram_en && ram_addr == $past(ram_addr)
                      && ram_wdata == DATA_W'($past(ram_rdata) + DATA_W'(1))));

    assert_invalid_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (!ram_en && !ram_we && !busy));

    assert_invalid_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |=> !pm_valid);

    assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !invalid);
endmodule

bind ptr_agu ptr_agu_chk #(.NUM_PTR(NUM_PTR), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_idx   (acc_idx),
    .acc_mod   (acc_mod),
    .acc_dbl   (acc_dbl),
    .peek_idx  (peek_idx),
    .peek_val  (peek_val),
    .ram_en    (ram_en),
    .ram_bank  (ram_bank),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata),
    .pm_valid  (pm_valid),
    .busy      (busy),
    .invalid   (invalid)
);

// File: tb/ptr_agu_bench.sv
module ptr_agu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_idx = '0;
    logic [1:0]  acc_mod = '0;
    logic        acc_dbl = 1'b0;
    logic [2:0]  loop_size = '0;
    logic        pw_en = 1'b0;
    logic [2:0]  pw_idx = '0;
    logic [7:0]  pw_data = '0;
    logic [2:0]  peek_idx = '0;
    logic [7:0]  peek_val;
    logic        ram_en, ram_bank, ram_we, pm_valid, busy, invalid;
    logic [7:0]  ram_addr;
    logic [15:0] ram_wdata, pm_addr;
    logic [15:0] ram_rdata = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ptr_agu u_ptr_agu (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
        .acc_mod(acc_mod), .acc_dbl(acc_dbl), .loop_size(loop_size),
        .pw_en(pw_en), .pw_idx(pw_idx), .pw_data(pw_data),
        .peek_idx(peek_idx), .peek_val(peek_val), .ram_en(ram_en),
        .ram_bank(ram_bank), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .pm_valid(pm_valid),
        .pm_addr(pm_addr), .busy(busy), .invalid(invalid)
    );

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic peek(input string what, input logic [2:0] idx, input logic [7:0] exp);
        peek_idx = idx;
        #1;
        check(what, 16'(peek_val), 16'(exp));
    endtask

    task automatic wr_ptr(input logic [2:0] idx, input logic [7:0] val);
        @(negedge clk);
        pw_en = 1'b1; pw_idx = idx; pw_data = val;
        @(negedge clk);
        pw_en = 1'b0;
    endtask

    // single-level access; checks bank/address, returns after update
    task automatic single(input string what, input logic [2:0] idx, input logic [1:0] m,
                          input logic exp_bank, input logic [7:0] exp_addr);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = idx; acc_mod = m; acc_dbl = 1'b0;
        #1;
        check({what, " ram_en"}, 16'(ram_en), 16'd1);
        check({what, " bank"}, 16'(ram_bank), 16'(exp_bank));
        check({what, " addr"}, 16'(ram_addr), 16'(exp_addr));
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check("R1 busy", 16'(busy), 16'd0);
        check("R1 ram_en", 16'(ram_en), 16'd0);
        check("R1 ram_we", 16'(ram_we), 16'd0);
        check("R1 pm_valid", 16'(pm_valid), 16'd0);
        check("R1 invalid", 16'(invalid), 16'd0);
        for (int i = 0; i < 8; i++) peek("R1 pointer", 3'(i), 8'h00);
    endtask

    task automatic t_write;
        wr_ptr(3'd0, 8'h10);
        wr_ptr(3'd1, 8'h20);
        wr_ptr(3'd5, 8'h7F);
        peek("R2 p0", 3'd0, 8'h10);
        peek("R2 p1", 3'd1, 8'h20);
        peek("R2 p5", 3'd5, 8'h7F);
        wr_ptr(3'd3, 8'h55);
        wr_ptr(3'd7, 8'hAA);
        peek("R3 p3", 3'd3, 8'h00);
        peek("R3 p7", 3'd7, 8'h00);
    endtask

    task automatic t_bank;
        single("R4 p0", 3'd0, 2'b00, 1'b0, 8'h10);
        single("R4 p5", 3'd5, 2'b00, 1'b1, 8'h7F);
        peek("R6 keep p0", 3'd0, 8'h10);
        peek("R6 keep p5", 3'd5, 8'h7F);
    endtask

    task automatic t_modes;
        loop_size = 3'd0;
        single("R6 inc", 3'd0, 2'b11, 1'b0, 8'h10);
        peek("R6 inc", 3'd0, 8'h11);
        single("R6 dec", 3'd0, 2'b10, 1'b0, 8'h11);
        peek("R6 dec", 3'd0, 8'h10);
        single("R6 incraw", 3'd0, 2'b01, 1'b0, 8'h10);
        peek("R6 incraw", 3'd0, 8'h11);
        wr_ptr(3'd1, 8'hFF);
        single("R6 wrap up", 3'd1, 2'b11, 1'b0, 8'hFF);
        peek("R6 wrap up", 3'd1, 8'h00);
        wr_ptr(3'd2, 8'h00);
        single("R6 wrap down", 3'd2, 2'b10, 1'b0, 8'h00);
        peek("R6 wrap down", 3'd2, 8'hFF);
    endtask

    task automatic t_loop;
        loop_size = 3'd4;
        wr_ptr(3'd4, 8'h1F);
        single("R7 inc mod16", 3'd4, 2'b11, 1'b1, 8'h1F);
        peek("R7 inc mod16", 3'd4, 8'h10);
        single("R7 dec mod16", 3'd4, 2'b10, 1'b1, 8'h10);
        peek("R7 dec mod16", 3'd4, 8'h1F);
        single("R6 incraw ignores loop", 3'd4, 2'b01, 1'b1, 8'h1F);
        peek("R6 incraw ignores loop", 3'd4, 8'h20);
        loop_size = 3'd7;
        wr_ptr(3'd6, 8'hFF);
        single("R7 inc mod128", 3'd6, 2'b11, 1'b1, 8'hFF);
        peek("R7 inc mod128", 3'd6, 8'h80);
        loop_size = 3'd1;
        wr_ptr(3'd6, 8'hA4);
        single("R7 dec mod2", 3'd6, 2'b10, 1'b1, 8'hA4);
        peek("R7 dec mod2", 3'd6, 8'hA5);
        loop_size = 3'd0;
    endtask

    task automatic t_fixed;
        single("R5 p3 m2", 3'd3, 2'b10, 1'b0, 8'h02);
        single("R5 p7 m1", 3'd7, 2'b01, 1'b1, 8'h01);
        single("R5 p7 m3", 3'd7, 2'b11, 1'b1, 8'h03);
        peek("R5 p3 unchanged", 3'd3, 8'h00);
        peek("R5 p7 unchanged", 3'd7, 8'h00);
    endtask

    task automatic dbl(input string what, input logic [2:0] idx, input logic [1:0] m,
                       input logic exp_bank, input logic [7:0] exp_addr, input logic [15:0] word);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = idx; acc_mod = m; acc_dbl = 1'b1;
        #1;
        check({what, " accept ram_en"}, 16'(ram_en), 16'd1);
        check({what, " accept addr"}, 16'(ram_addr), 16'(exp_addr));
        check({what, " accept bank"}, 16'(ram_bank), 16'(exp_bank));
        @(negedge clk);
        ram_rdata = word;
        acc_idx = 3'd1; acc_mod = 2'b11;  // R11: request while busy must be ignored
        #1;
        check({what, " fetch pm_valid"}, 16'(pm_valid), 16'd1);
        check({what, " fetch pm_addr"}, pm_addr, word);
        check({what, " fetch busy"}, 16'(busy), 16'd1);
        check("R11 busy no invalid", 16'(invalid), 16'd0);
        @(negedge clk);
        acc_valid = 1'b0; acc_dbl = 1'b0;
        ram_rdata = 16'hDEAD;
        #1;
        check({what, " wback we"}, 16'(ram_we), 16'd1);
        check({what, " wback addr"}, 16'(ram_addr), 16'(exp_addr));
        check({what, " wback bank"}, 16'(ram_bank), 16'(exp_bank));
        check({what, " wback data"}, ram_wdata, word + 16'd1);
        @(negedge clk);
        #1;
        check({what, " idle"}, 16'(busy), 16'd0);
        check({what, " idle pm_valid"}, 16'(pm_valid), 16'd0);
    endtask

    task automatic t_double;
        wr_ptr(3'd4, 8'h40);
        wr_ptr(3'd1, 8'h20);
        dbl("R8 p4", 3'd4, 2'b00, 1'b1, 8'h40, 16'h1234);
        peek("R8 p4 unchanged", 3'd4, 8'h40);
        peek("R11 p1 unchanged", 3'd1, 8'h20);
        dbl("R8 wrap", 3'd0, 2'b00, 1'b0, 8'h11, 16'hFFFF);
        dbl("R8 fixed", 3'd3, 2'b10, 1'b0, 8'h02, 16'h0400);
    endtask

    task automatic t_invalid;
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = 3'd1; acc_mod = 2'b11; acc_dbl = 1'b1;
        #1;
        check("R9 invalid", 16'(invalid), 16'd1);
        check("R9 no ram_en", 16'(ram_en), 16'd0);
        @(negedge clk);
        acc_valid = 1'b0; acc_dbl = 1'b0;
        #1;
        check("R9 no busy", 16'(busy), 16'd0);
        check("R9 no pm", 16'(pm_valid), 16'd0);
        check("R9 invalid cleared", 16'(invalid), 16'd0);
        peek("R9 p1 unchanged", 3'd1, 8'h20);
    endtask

    task automatic t_collide;
        wr_ptr(3'd0, 8'h10);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = 3'd0; acc_mod = 2'b11; acc_dbl = 1'b0;
        pw_en = 1'b1; pw_idx = 3'd0; pw_data = 8'h80;
        @(negedge clk);
        acc_valid = 1'b0; pw_en = 1'b0;
        peek("R10 same ptr write wins", 3'd0, 8'h80);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = 3'd0; acc_mod = 2'b11;
        pw_en = 1'b1; pw_idx = 3'd1; pw_data = 8'h33;
        @(negedge clk);
        acc_valid = 1'b0; pw_en = 1'b0;
        peek("R10 other ptr step", 3'd0, 8'h81);
        peek("R10 other ptr write", 3'd1, 8'h33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_bank();
        t_modes();
        t_loop();
        t_fixed();
        t_double();
        t_invalid();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule